// File: doc/BRIEF.md
# DMA Descriptor Table Generator

This block turns a list of buffer segments, each an address and a byte length, into a scatter-gather descriptor table held in a local word-addressed memory. A requester presents the segments one at a time on a valid/ready stream and flags the final one. The block cuts each segment into chunks so that no chunk crosses a 64 KiB address boundary. It writes one four-word descriptor per chunk and then sets an end-of-list flag in the last descriptor.

When the list is complete, the block pulses `done` with the number of descriptors written. The table holds a fixed number of entries. If one more chunk would be needed, the block abandons the table and reports overflow with a count of zero, so the requester can fall back to programmed I/O. A count of zero without overflow means the list was empty and no DMA should start.

Top module: `desc_table_gen`

## Requirements
- R1: Each chunk starts at the current address and carries min(0x10000 - (address mod 0x10000), bytes left in the segment) bytes; the next chunk starts at address plus that length.
- R2: Descriptor k occupies memory words 4k to 4k+3. Word 4k and word 4k+2 are zero. Word 4k+1 is the chunk address and word 4k+3 is the chunk length, both byte-reversed (big-endian byte order; address bits 7:0 land in data bits 31:24).
- R3: The table holds ENTRIES (64) descriptors. If chunk ENTRIES+1 is needed, the block writes nothing more and pulses `done` with `done_ovf` = 1 and `done_count` = 0. The descriptors already written carry no end-of-list flag.
- R4: After the final chunk of a list, the length word of the last descriptor is rewritten with bit 31 of the length set; after byte reversal this is data bit 7. No other descriptor carries the flag.
- R5: A list whose first segment has length zero writes no memory word and reports `done_count` = 0 with `done_ovf` = 0.
- R6: A segment of length zero ends the list at that point. The block still accepts the remaining segments up to and including the one marked `seg_last`, and they write nothing and do not change the result.
- R7: `done` is a single-cycle pulse. For a non-empty list without overflow, it comes in the cycle right after the last memory write, and `done_count` equals the number of descriptors.
- R8: `seg_ready` is low in every cycle in which the block writes memory.
- R9: After reset, `seg_ready` is 1 and `done` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when both are high |
| seg_addr | input | ADDR_W (32) | Segment start address in bytes |
| seg_len | input | LEN_W (32) | Segment length in bytes |
| seg_last | input | 1 | Marks the final segment of the list |
| mem_we | output | 1 | Table memory write strobe |
| mem_addr | output | log2(ENTRIES)+2 (8) | Table memory word index |
| mem_wdata | output | 32 | Table memory write data |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | log2(ENTRIES+1) (7) | Descriptors written, 0 on overflow or empty list |
| done_ovf | output | 1 | Table capacity exceeded |

## Verification
The assertions assume the requester holds a segment's address, length and last flag steady while `seg_valid` is high and `seg_ready` is low. They also assume every list ends with a segment marked `seg_last`, and that segment lengths and addresses do not make the address wrap past the top of the 32-bit space. The bench changes its inputs only at falling edges and keeps each segment stable until its handshake. It ends every list with a last-marked segment and draws random addresses from the lower range, skewed toward positions just below a 64 KiB boundary. Random lengths stay small enough that most lists fit in the table, and directed lists hit exactly full, one-over and zero-length cases.

// File: rtl/desc_gen_pkg.sv
package desc_gen_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMIT,
        ST_EOL,
        ST_DONE,
        ST_DRAIN
    } gen_state_e;

    // Reverse the byte order of one table word (big-endian table layout).
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[(WORD_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/dg_chunk.sv
module dg_chunk #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 32,
    parameter int BOUND_W = 16
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   rem_len,
    output logic [BOUND_W:0]   chunk_len
);
    localparam logic [BOUND_W:0] SPAN = {1'b1, {BOUND_W{1'b0}}};

    logic [BOUND_W:0] to_bound;

    always_comb begin
        to_bound = SPAN - {1'b0, cur_addr[BOUND_W-1:0]};
        if (rem_len < LEN_W'(to_bound)) begin
            chunk_len = rem_len[BOUND_W:0];
        end else begin
            chunk_len = to_bound;
        end
    end
endmodule

// File: rtl/dg_word_fmt.sv
module dg_word_fmt
    import desc_gen_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BOUND_W = 16
) (
    input  logic [1:0]         word_sel,
    input  logic [ADDR_W-1:0]  ent_addr,
    input  logic [BOUND_W:0]   ent_len,
    input  logic               ent_eol,
    output logic [WORD_W-1:0]  word
);
    logic [WORD_W-1:0] len_word;
    logic [WORD_W-1:0] addr_word;

    always_comb begin
        addr_word = WORD_W'(ent_addr);
        len_word  = WORD_W'(ent_len);
        len_word[WORD_W-1] = ent_eol;
        unique case (word_sel)
            2'd1:    word = swap_bytes(addr_word);
            2'd3:    word = swap_bytes(len_word);
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/desc_table_gen.sv
module desc_table_gen
    import desc_gen_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 32,
    parameter int BOUND_W = 16,
    localparam int EW     = $clog2(ENTRIES),
    localparam int CW     = $clog2(ENTRIES + 1),
    localparam int MAW    = EW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    output logic              mem_we,
    output logic [MAW-1:0]    mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              done,
    output logic [CW-1:0]     done_count,
    output logic              done_ovf
);
    typedef struct packed {
        gen_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [1:0]        widx;
        logic [CW-1:0]     cnt;
        logic [BOUND_W:0]  last_len;
        logic              seg_last;
        logic              drain;
        logic              ovf;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, addr: '0, rem: '0, widx: '0, cnt: '0,
        last_len: '0, seg_last: 1'b0, drain: 1'b0, ovf: 1'b0
    };

    regs_t r_q, r_d;

    logic [BOUND_W:0] chunk_len;
    logic [1:0]       fmt_sel;
    logic [BOUND_W:0] fmt_len;
    logic             fmt_eol;
    logic [31:0]      fmt_word;
    logic [CW-1:0]    last_idx;

    dg_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BOUND_W(BOUND_W)) u_chunk (
        .cur_addr  (r_q.addr),
        .rem_len   (r_q.rem),
        .chunk_len (chunk_len)
    );

    dg_word_fmt #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_fmt (
        .word_sel (fmt_sel),
        .ent_addr (r_q.addr),
        .ent_len  (fmt_len),
        .ent_eol  (fmt_eol),
        .word     (fmt_word)
    );

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_addr  = '0;
        fmt_sel   = r_q.widx;
        fmt_len   = chunk_len;
        fmt_eol   = 1'b0;
        last_idx  = r_q.cnt - 1'b1;
        seg_ready = (r_q.st == ST_IDLE) || (r_q.st == ST_DRAIN);

        unique case (r_q.st)
            ST_IDLE: begin
                if (seg_valid) begin
                    r_d.seg_last = seg_last;
                    r_d.drain    = !seg_last;
                    if (seg_len == '0) begin
                        r_d.drain = !seg_last;
                        r_d.st    = (r_q.cnt == '0) ? ST_DONE : ST_EOL;
                    end else begin
                        r_d.drain = 1'b0;
                        r_d.addr  = seg_addr;
                        r_d.rem   = seg_len;
                        r_d.widx  = 2'd0;
                        r_d.st    = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (r_q.widx == 2'd0 && r_q.cnt == CW'(ENTRIES)) begin
                    r_d.ovf   = 1'b1;
                    r_d.drain = !r_q.seg_last;
                    r_d.st    = ST_DONE;
                end else begin
                    mem_we   = 1'b1;
                    mem_addr = {r_q.cnt[EW-1:0], r_q.widx};
                    r_d.widx = r_q.widx + 2'd1;
                    if (r_q.widx == 2'd3) begin
                        r_d.cnt      = r_q.cnt + 1'b1;
                        r_d.addr     = r_q.addr + ADDR_W'(chunk_len);
                        r_d.rem      = r_q.rem - LEN_W'(chunk_len);
                        r_d.last_len = chunk_len;
                        if (r_q.rem == LEN_W'(chunk_len)) begin
                            r_d.st = r_q.seg_last ? ST_EOL : ST_IDLE;
                        end
                    end
                end
            end
            ST_EOL: begin
                mem_we   = 1'b1;
                mem_addr = {last_idx[EW-1:0], 2'd3};
                fmt_sel  = 2'd3;
                fmt_len  = r_q.last_len;
                fmt_eol  = 1'b1;
                r_d.st   = ST_DONE;
            end
            ST_DONE: begin
                r_d.st    = r_q.drain ? ST_DRAIN : ST_IDLE;
                r_d.cnt   = '0;
                r_d.ovf   = 1'b0;
                r_d.drain = 1'b0;
            end
            ST_DRAIN: begin
                if (seg_valid && seg_last) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        mem_wdata  = fmt_word;
        done       = (r_q.st == ST_DONE);
        done_count = r_q.ovf ? '0 : r_q.cnt;
        done_ovf   = (r_q.st == ST_DONE) && r_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: no segment is taken while the table is being written
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !seg_ready);

    // R7: completion is a one-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a non-empty good list finishes right after its last write
    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ovf && done_count != '0) |-> $past(mem_we));

    // R3: overflow reports a zero count
    p_ovf_count_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ovf) |-> (done_count == '0));

    // R3: the entry counter never exceeds the table size
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(ENTRIES));

    // R9: reset leaves the block idle
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_we && seg_ready));

endmodule

// File: tb/desc_table_gen_test.sv
module desc_table_gen_test;
    localparam int ENT = 64;
    localparam int MW  = ENT * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_valid = 1'b0;
    logic        seg_ready;
    logic [31:0] seg_addr = '0;
    logic [31:0] seg_len = '0;
    logic        seg_last = 1'b0;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        done;
    logic [6:0]  done_count;
    logic        done_ovf;

    always #4 clk = ~clk;

    desc_table_gen uut (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .done_count(done_count), .done_ovf(done_ovf)
    );

    int unsigned vectors = 0;
    int unsigned errors  = 0;

    logic [31:0] got_mem [MW];
    logic [31:0] exp_mem [MW];
    int          exp_cnt;
    logic        exp_ovf;
    int          ncyc = 0;
    int          last_wr_cyc = -10;
    int          done_cyc;
    int          n_done;
    int          d_cnt;
    logic        d_ovf;

    logic [31:0] la [8];
    logic [31:0] ll [8];
    int          nseg;

    always @(negedge clk) begin
        ncyc <= ncyc + 1;
        if (rst_n && mem_we) begin
            got_mem[mem_addr] <= mem_wdata;
            last_wr_cyc <= ncyc;
        end
        if (rst_n && done) begin
            n_done   <= n_done + 1;
            done_cyc <= ncyc;
            d_cnt    <= int'(done_count);
            d_ovf    <= done_ovf;
        end
    end

    function automatic logic [31:0] be(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Expected table from R1..R6
    task automatic build_expected();
        int cnt = 0;
        logic ovf = 1'b0;
        logic [31:0] lastlen = '0;
        for (int i = 0; i < MW; i++) exp_mem[i] = 32'hA5A5_A5A5;
        for (int s = 0; s < nseg && !ovf; s++) begin
            logic [31:0] a = la[s];
            logic [31:0] rem = ll[s];
            if (rem == 0) break;
            while (rem != 0) begin
                logic [31:0] c = 32'h1_0000 - {16'h0, a[15:0]};
                if (c > rem) c = rem;
                if (cnt == ENT) begin
                    ovf = 1'b1;
                    break;
                end
                exp_mem[cnt*4]   = 32'h0;
                exp_mem[cnt*4+1] = be(a);
                exp_mem[cnt*4+2] = 32'h0;
                exp_mem[cnt*4+3] = be(c);
                lastlen = c;
                cnt++;
                a = a + c;
                rem = rem - c;
            end
        end
        if (!ovf && cnt > 0) exp_mem[(cnt-1)*4+3] = be(lastlen | 32'h8000_0000);
        exp_ovf = ovf;
        exp_cnt = ovf ? 0 : cnt;
    endtask

    task automatic run_list(input string tag);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < MW; i++) got_mem[i] = 32'hA5A5_A5A5;
        n_done = 0;
        build_expected();
        @(negedge clk);
        for (int s = 0; s < nseg; s++) begin
            bit hs;
            seg_valid = 1'b1;
            seg_addr  = la[s];
            seg_len   = ll[s];
            seg_last  = (s == nseg - 1);
            do begin
                hs = seg_ready;
                @(negedge clk);
            end while (!hs);
        end
        seg_valid = 1'b0;
        seg_last  = 1'b0;
        for (int w = 0; w < 400 && n_done == 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(n_done == 1, "R7", {tag, " done pulse count"}, n_done, 1);
        check(d_ovf == exp_ovf, "R3", {tag, " overflow flag"}, d_ovf, exp_ovf);
        check(d_cnt == exp_cnt, "R7", {tag, " descriptor count"}, d_cnt, exp_cnt);
        for (int i = 0; i < MW; i++) begin
            if (got_mem[i] !== exp_mem[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        // R1 R2 R4 R5 R6: whole table contents, including untouched words
        check(mism == 0, "R1/R2/R4", {tag, " table word"}, got_mem[first], exp_mem[first]);
        if (!exp_ovf && exp_cnt > 0)
            check(done_cyc == last_wr_cyc + 1, "R7", {tag, " done timing"},
                  done_cyc - last_wr_cyc, 1);
        check(seg_ready == 1'b1, "R8", {tag, " ready after list"}, seg_ready, 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_EED5));
        repeat (3) @(negedge clk);
        check(seg_ready == 1'b1, "R9", "reset ready", seg_ready, 1);
        check(done == 1'b0, "R9", "reset done", done, 0);
        check(mem_we == 1'b0, "R9", "reset write", mem_we, 0);
        rst_n = 1'b1;

        // R1: aligned full 64 KiB chunk
        nseg = 1; la[0] = 32'h0003_0000; ll[0] = 32'h1_0000;
        run_list("aligned");
        // R1: boundary crossing splits in two
        nseg = 1; la[0] = 32'h1234_FFF0; ll[0] = 32'h20;
        run_list("cross");
        // R5: empty list
        nseg = 1; la[0] = 32'h100; ll[0] = 0;
        run_list("empty");
        // R6: zero length in the middle drops the rest
        nseg = 3; la[0] = 32'h2000; ll[0] = 32'h40; la[1] = 0; ll[1] = 0;
        la[2] = 32'h9000; ll[2] = 32'h80;
        run_list("zero_mid");
        // R3: exactly full table
        nseg = 1; la[0] = 32'h0; ll[0] = 32'h40_0000;
        run_list("full");
        // R3: one entry too many
        nseg = 1; la[0] = 32'h0; ll[0] = 32'h40_0001;
        run_list("overflow");
        // R3: overflow with segments still queued
        nseg = 3; la[0] = 32'h10; ll[0] = 32'h40_0000; la[1] = 32'h5; ll[1] = 32'h9;
        la[2] = 32'h77; ll[2] = 32'h3;
        run_list("ovf_drain");
        // R5 + R6: empty then trailing segments
        nseg = 2; la[0] = 32'h0; ll[0] = 0; la[1] = 32'h4000; ll[1] = 32'h10;
        run_list("empty_drain");

        for (int t = 0; t < 40; t++) begin
            nseg = 1 + int'($urandom_range(0, 4));
            for (int s = 0; s < nseg; s++) begin
                logic [31:0] a = $urandom_range(0, 32'h7FFF_FFFF);
                if ($urandom_range(0, 2) == 0) a[15:0] = 16'hFFFF - 16'($urandom_range(0, 63));
                la[s] = a;
                case ($urandom_range(0, 3))
                    0: ll[s] = $urandom_range(1, 512);
                    1: ll[s] = $urandom_range(1, 32'h3_0000);
                    2: ll[s] = $urandom_range(32'hFFF0, 32'h1_0010);
                    default: ll[s] = $urandom_range(1, 32'h8000);
                endcase
            end
            run_list("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule